// File: doc/BRIEF.md
# Condition-Field Predicate Mask Extractor

This block sits next to the condition register file and turns its wide read port, which presents all eight 4-bit condition fields at once, into an 8-bit predicate mask. Only that 8-bit mask is sent on the bus toward the SIMD function units, not all 32 bits. For each field the block picks one bit, chosen by a 2-bit selector. It then trims the mask to the number of lanes that the element width implies: eight lanes of 8 bits, four of 16, two of 32 or one of 64.

An unpredicated operation sets every active lane of the mask to one. The function units then run as if no predicate were present. The request is sampled when the input valid is high. The mask is registered and appears one cycle later with an output valid. The mask holds its last value while no request arrives.

Top module: `cr_pred_extract`

## Requirements
- R1: Condition field i occupies bits [4*i+3:4*i] of `cr_all_i`. With element width code 2'b11 (8-bit elements) and `unpred_i` low, mask bit i equals `cr_all_i[4*i + bit_sel_i]` for all eight lanes.
- R2: With width code 2'b10 (16-bit elements), mask bits 3:0 are extracted as in R1 and bits 7:4 are 0.
- R3: With width code 2'b01 (32-bit elements), mask bits 1:0 are extracted as in R1 and bits 7:2 are 0.
- R4: With width code 2'b00 (64-bit elements), mask bit 0 is extracted from field 0 as in R1 and bits 7:1 are 0.
- R5: With `unpred_i` high, the mask is 1 in every lane that the width code makes active and 0 elsewhere, whatever `cr_all_i` and `bit_sel_i` hold.
- R6: A request sampled on a rising edge with `in_valid_i` high shows its mask after that edge, with `out_valid_o` high. After an edge with `in_valid_i` low, `out_valid_o` is low.
- R7: After an edge with `in_valid_i` low, `pred_mask_o` keeps its previous value, whatever the other inputs do.
- R8: While `rst_ni` is low, `out_valid_o` and `pred_mask_o` are 0. The reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid, samples the other inputs |
| cr_all_i | input | 32 | All eight condition fields, field i at bits [4*i+3:4*i] |
| bit_sel_i | input | 2 | Bit position picked inside every field |
| elem_w_i | input | 2 | Element width: 00=64, 01=32, 10=16, 11=8 bits |
| unpred_i | input | 1 | Unpredicated operation, forces active lanes to 1 |
| out_valid_o | output | 1 | Mask valid, one cycle after the request |
| pred_mask_o | output | 8 | Predicate mask, lane i in bit i |

## Verification
The bench uses condition patterns in which each field holds a distinct one-hot or alternating nibble. A design that reversed the field order, or that indexed the bit selector across fields instead of within them, would then produce a visibly wrong mask. Each width code is run with all-ones fields, so a design that failed to clear the inactive upper lanes, or that kept the wrong lanes, would leak ones into bits that must be 0. Unpredicated requests are run with all-zero fields at every width; a design that let the condition contents through, or that set the inactive lanes, would show it. Idle cycles with changing inputs, and a reset in the middle of a run, expose a mask that is not held or an output valid that is not cleared.

// File: rtl/cr_pred_pkg.sv
package cr_pred_pkg;
  localparam int unsigned NUM_FIELDS = 8;
  localparam int unsigned FIELD_W    = 4;
  localparam int unsigned EW_W       = 2;

  typedef enum logic [EW_W-1:0] {
    EW_64 = 2'b00,
    EW_32 = 2'b01,
    EW_16 = 2'b10,
    EW_8  = 2'b11
  } elem_w_e;

  // lanes active for a width code: 1 << code, capped at lane count
  function automatic int unsigned lanes_for(input logic [EW_W-1:0] ew, input int unsigned max_l);
    int unsigned n;
    n = 32'd1 << ew;
    return (n > max_l) ? max_l : n;
  endfunction
endpackage

// File: rtl/cr_bit_picker.sv
module cr_bit_picker #(
  parameter int unsigned NUM_FIELDS = cr_pred_pkg::NUM_FIELDS,
  parameter int unsigned FIELD_W    = cr_pred_pkg::FIELD_W,
  localparam int unsigned CR_W      = NUM_FIELDS * FIELD_W,
  localparam int unsigned SEL_W     = $clog2(FIELD_W)
) (
  input  logic [CR_W-1:0]       cr_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic [NUM_FIELDS-1:0] picked_o
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic [FIELD_W-1:0] field;
    assign field       = cr_i[g*FIELD_W +: FIELD_W];
    assign picked_o[g] = field[sel_i];
  end
endmodule

// File: rtl/cr_lane_trim.sv
module cr_lane_trim #(
  parameter int unsigned NUM_FIELDS = cr_pred_pkg::NUM_FIELDS,
  localparam int unsigned EW_W      = cr_pred_pkg::EW_W
) (
  input  logic [NUM_FIELDS-1:0] picked_i,
  input  logic [EW_W-1:0]       elem_w_i,
  input  logic                  unpred_i,
  output logic [NUM_FIELDS-1:0] mask_o
);
  logic [NUM_FIELDS-1:0] lane_en;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_lane
    assign lane_en[g] = (g < cr_pred_pkg::lanes_for(elem_w_i, NUM_FIELDS));
    assign mask_o[g]  = lane_en[g] & (unpred_i | picked_i[g]);
  end
endmodule

// File: rtl/cr_pred_reg.sv
module cr_pred_reg #(
  parameter int unsigned W = cr_pred_pkg::NUM_FIELDS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/cr_pred_extract.sv
module cr_pred_extract #(
  parameter int unsigned NUM_FIELDS = cr_pred_pkg::NUM_FIELDS,
  parameter int unsigned FIELD_W    = cr_pred_pkg::FIELD_W,
  localparam int unsigned CR_W      = NUM_FIELDS * FIELD_W,
  localparam int unsigned SEL_W     = $clog2(FIELD_W),
  localparam int unsigned EW_W      = cr_pred_pkg::EW_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic [CR_W-1:0]       cr_all_i,
  input  logic [SEL_W-1:0]      bit_sel_i,
  input  logic [EW_W-1:0]       elem_w_i,
  input  logic                  unpred_i,
  output logic                  out_valid_o,
  output logic [NUM_FIELDS-1:0] pred_mask_o
);
  logic [NUM_FIELDS-1:0] picked;
  logic [NUM_FIELDS-1:0] mask_d;

  cr_bit_picker #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_pick (
    .cr_i     (cr_all_i),
    .sel_i    (bit_sel_i),
    .picked_o (picked)
  );

  cr_lane_trim #(.NUM_FIELDS(NUM_FIELDS)) u_trim (
    .picked_i (picked),
    .elem_w_i (elem_w_i),
    .unpred_i (unpred_i),
    .mask_o   (mask_d)
  );

  cr_pred_reg #(.W(NUM_FIELDS)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (in_valid_i),
    .d_i     (mask_d),
    .valid_o (out_valid_o),
    .q_o     (pred_mask_o)
  );
endmodule

// File: rtl/cr_pred_extract_chk.sv
module cr_pred_extract_chk #(
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned FIELD_W    = 4,
  localparam int unsigned CR_W      = NUM_FIELDS * FIELD_W,
  localparam int unsigned SEL_W     = $clog2(FIELD_W)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  in_valid_i,
  input logic [CR_W-1:0]       cr_all_i,
  input logic [SEL_W-1:0]      bit_sel_i,
  input logic [1:0]            elem_w_i,
  input logic                  unpred_i,
  input logic                  out_valid_o,
  input logic [NUM_FIELDS-1:0] pred_mask_o
);
  assert_valid_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  assert_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  assert_mask_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(pred_mask_o));

  assert_w64_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && elem_w_i == 2'b00) |=> (pred_mask_o[NUM_FIELDS-1:1] == '0));

  assert_w16_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && elem_w_i == 2'b10) |=> (pred_mask_o[NUM_FIELDS-1:4] == '0));

  assert_w32_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && elem_w_i == 2'b01) |=> (pred_mask_o[NUM_FIELDS-1:2] == '0));

  assert_unpred_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && unpred_i && elem_w_i == 2'b11) |=> (pred_mask_o == '1));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R8: assert (!out_valid_o && pred_mask_o == '0);
    end
  end
endmodule

bind cr_pred_extract cr_pred_extract_chk #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/cr_pred_extract_tb_top.sv
module cr_pred_extract_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  typedef struct packed {
    logic [31:0] cr;
    logic [1:0]  sel;
    logic [1:0]  ew;
    logic        unp;
    logic [7:0]  exp;
  } vec_t;

  // widths: 00=64 01=32 10=16 11=8
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 2'd0, 2'b11, 1'b0, 8'h00},  // R1
    '{32'h1111_1111, 2'd0, 2'b11, 1'b0, 8'hFF},  // R1
    '{32'h1111_1111, 2'd1, 2'b11, 1'b0, 8'h00},  // R1
    '{32'h8421_8421, 2'd2, 2'b11, 1'b0, 8'h44},  // R1
    '{32'h8421_8421, 2'd3, 2'b11, 1'b0, 8'h88},  // R1
    '{32'hA5A5_A5A5, 2'd0, 2'b11, 1'b0, 8'h55},  // R1
    '{32'hA5A5_A5A5, 2'd1, 2'b11, 1'b0, 8'hAA},  // R1
    '{32'h8421_8421, 2'd0, 2'b10, 1'b0, 8'h01},  // R2
    '{32'hFFFF_FFFF, 2'd1, 2'b10, 1'b0, 8'h0F},  // R2
    '{32'hFFFF_FFFF, 2'd3, 2'b01, 1'b0, 8'h03},  // R3
    '{32'h0000_00F0, 2'd0, 2'b01, 1'b0, 8'h02},  // R3
    '{32'hFFFF_FFFF, 2'd2, 2'b00, 1'b0, 8'h01},  // R4
    '{32'h0000_00F0, 2'd0, 2'b00, 1'b0, 8'h00},  // R4
    '{32'h0000_0000, 2'd0, 2'b11, 1'b1, 8'hFF},  // R5
    '{32'h0000_0000, 2'd2, 2'b10, 1'b1, 8'h0F},  // R5
    '{32'h0000_0000, 2'd1, 2'b01, 1'b1, 8'h03},  // R5
    '{32'h0000_0000, 2'd3, 2'b00, 1'b1, 8'h01}   // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] cr_all = '0;
  logic [1:0]  bit_sel = '0;
  logic [1:0]  elem_w = '0;
  logic        unpred = 1'b0;
  logic        out_valid;
  logic [7:0]  pred_mask;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cr_pred_extract dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .cr_all_i    (cr_all),
    .bit_sel_i   (bit_sel),
    .elem_w_i    (elem_w),
    .unpred_i    (unpred),
    .out_valid_o (out_valid),
    .pred_mask_o (pred_mask)
  );

  function automatic logic [7:0] model(logic [31:0] cr, logic [1:0] sel, logic [1:0] ew, logic unp);
    logic [7:0] m;
    int lanes;
    lanes = 1 << ew;
    m = '0;
    for (int i = 0; i < 8; i++)
      if (i < lanes) m[i] = unp ? 1'b1 : cr[4*i + int'(sel)];
    return m;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(logic [31:0] cr, logic [1:0] sel, logic [1:0] ew, logic unp);
    @(negedge clk);
    in_valid = 1'b1; cr_all = cr; bit_sel = sel; elem_w = ew; unpred = unp;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset valid", {7'd0, out_valid}, 8'h00);
    chk("R8 reset mask", pred_mask, 8'h00);
    rst_n = 1'b1;

    // table walk, one request per vector
    for (int k = 0; k < NVEC; k++) begin
      send(VECS[k].cr, VECS[k].sel, VECS[k].ew, VECS[k].unp);
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R6 valid vec%0d", k), {7'd0, out_valid}, 8'h01);
      chk($sformatf("R1-5 mask vec%0d ew%0d unp%0d", k, VECS[k].ew, VECS[k].unp), pred_mask, VECS[k].exp);
    end

    // R6 idle cycle drops valid; R7 mask held while inputs change
    held = pred_mask;
    @(negedge clk);
    cr_all = 32'hFFFF_FFFF; elem_w = 2'b11; unpred = 1'b1;
    @(negedge clk);
    chk("R6 idle valid low", {7'd0, out_valid}, 8'h00);
    chk("R7 mask held", pred_mask, held);

    // R6 back-to-back stream, each result one cycle after its request
    send(32'h0000_000F, 2'd0, 2'b11, 1'b0);
    send(32'h0000_00F0, 2'd0, 2'b11, 1'b0);
    chk("R6 stream first", pred_mask, 8'h01);
    chk("R6 stream first valid", {7'd0, out_valid}, 8'h01);
    send(32'hF000_0000, 2'd3, 2'b11, 1'b0);
    chk("R6 stream second", pred_mask, 8'h02);
    idle();
    chk("R6 stream third", pred_mask, 8'h80);

    // R5 unpred ignores bit select and contents (all ones fields vs zero)
    send(32'hFFFF_FFFF, 2'd1, 2'b10, 1'b1);
    idle();
    chk("R5 unpred ones cr ew16", pred_mask, 8'h0F);

    // random sweep against requirement model
    for (int k = 0; k < 200; k++) begin
      logic [31:0] c; logic [1:0] s; logic [1:0] e; logic u;
      c = $urandom; s = 2'($urandom); e = 2'($urandom); u = (($urandom % 5) == 0);
      send(c, s, e, u);
      idle();
      chk($sformatf("R1 R2 R3 R4 R5 rand%0d", k), pred_mask, model(c, s, e, u));
    end

    // R8 asynchronous reset mid-run
    send(32'hFFFF_FFFF, 2'd0, 2'b11, 1'b0);
    @(negedge clk);
    chk("R8 pre-reset mask", pred_mask, 8'hFF);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    chk("R8 async clear valid", {7'd0, out_valid}, 8'h00);
    chk("R8 async clear mask", pred_mask, 8'h00);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 after reset valid", {7'd0, out_valid}, 8'h00);

    finish_run();
  end
endmodule